// File: doc/BRIEF.md
# Byte Shift, Rotate and Nibble-Exchange Unit

This unit performs the single-position rotates and shifts of an 8-bit processor data path, together with two three-way nibble rotations that move half-bytes between the accumulator and a memory byte. A 4-bit operation select chooses the operation. The block takes an operand byte, the accumulator, a memory byte and the incoming flag byte. The carry input is bit 0 of that flag byte. The block returns a result byte, the new accumulator, the new memory byte and the updated flag byte. All four outputs are registered, so they follow the inputs by one clock.

Operand selection and the memory read and write are done outside the unit. The caller presents the bytes and writes back whichever outputs the operation produces. The four short accumulator forms take their data from the accumulator input and ignore the operand. They change only the carry, half-carry and subtract flags, so sign, zero and parity pass through.

Top module: `srn_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, result, acc_out, mem_out and flags_out become 0. When rst_n is high, every output holds the value computed from the inputs sampled at the previous rising edge, so the latency is one cycle.
- R2: op_sel 0 rotates the operand left circularly, with old bit 7 going to bit 0 and to carry. op_sel 1 rotates it right circularly, with old bit 0 going to bit 7 and to carry.
- R3: op_sel 2 rotates left through carry: old bit 7 goes to carry and the incoming carry (flags_in bit 0) goes to bit 0. op_sel 3 rotates right through carry: old bit 0 goes to carry and the incoming carry goes to bit 7.
- R4: op_sel 4 shifts left and loads 0 into bit 0, with bit 7 going to carry. op_sel 5 shifts right and keeps bit 7, with bit 0 going to carry. op_sel 6 shifts right and loads 0 into bit 7, with bit 0 going to carry.
- R5: The flag layout is S bit 7, Z bit 6, H bit 4, P/V bit 2, N bit 1 and C bit 0. For op_sel 0 to 6: S is result bit 7, Z is 1 when the result is 0, P/V is 1 when the result has an even number of ones, H and N are 0, and C is the bit shifted out.
- R6: op_sel 8, 9, 10 and 11 apply the operations of op_sel 0, 1, 2 and 3 to acc_in and ignore the operand. Result and acc_out both carry the rotated value. C is the bit shifted out, H and N are 0, and S, Z and P/V are copied from flags_in.
- R7: op_sel 12 (left nibble rotation) produces mem_out = {mem_in[3:0], acc_in[3:0]} and acc_out = {acc_in[7:4], mem_in[7:4]}, and result equals acc_out.
- R8: op_sel 13 (right nibble rotation) produces mem_out = {acc_in[3:0], mem_in[7:4]} and acc_out = {acc_in[7:4], mem_in[3:0]}, and result equals acc_out.
- R9: For op_sel 12 and 13, S, Z and P/V are computed from the new accumulator as in R5, H and N are 0, and C is copied from flags_in.
- R10: flags_out bits 5 and 3 always equal flags_in bits 5 and 3.
- R11: op_sel 7, 14 and 15 are reserved. For them result equals the operand, flags_out equals flags_in, acc_out equals acc_in and mem_out equals mem_in.
- R12: For op_sel 0 to 6, acc_out equals acc_in and mem_out equals mem_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation select |
| operand | input | 8 | Byte for the full rotate and shift forms |
| acc_in | input | 8 | Accumulator value |
| mem_in | input | 8 | Memory byte for nibble rotations |
| flags_in | input | 8 | Incoming flag byte; bit 0 is carry in |
| result | output | 8 | Result byte |
| acc_out | output | 8 | New accumulator |
| mem_out | output | 8 | New memory byte |
| flags_out | output | 8 | Updated flag byte |

## Verification
Directed bytes with only the edge bits set (0x80, 0x01, 0x81) separate circular rotation, rotation through carry and the shifts. Each shift type treats the bit shifted in, the bit kept and the bit shifted out differently, and an outgoing bit that empties the byte also exercises the zero flag. Distinct nibble values in the accumulator and the memory byte (0x12 against 0x34) make any wrong nibble routing visible in both nibble rotations. Random operands, accumulators, memory bytes and flag bytes are applied for every select value, including the reserved ones. They show whether the carry-in is used, whether the flag bits that should pass through do pass through, and whether the operand is ignored for the accumulator forms.

// File: rtl/srn_pkg.sv
// Shared encodings for the shift/rotate unit: operation codes, operation
// classes, flag bit positions and an even-parity helper.
package srn_pkg;

    // Operation select values; the low bits of the full and accumulator
    // forms select the shifter kind directly.
    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,  OP_RRC  = 4'd1,  OP_RL   = 4'd2,  OP_RR   = 4'd3,
        OP_SLA  = 4'd4,  OP_SRA  = 4'd5,  OP_SRL  = 4'd6,  OP_RSV7 = 4'd7,
        OP_ARLC = 4'd8,  OP_ARRC = 4'd9,  OP_ARL  = 4'd10, OP_ARR  = 4'd11,
        OP_NIBL = 4'd12, OP_NIBR = 4'd13, OP_RSVE = 4'd14, OP_RSVF = 4'd15
    } srn_op_e;

    typedef enum logic [1:0] {
        CLS_FULL = 2'd0,
        CLS_ACC  = 2'd1,
        CLS_NIB  = 2'd2,
        CLS_PASS = 2'd3
    } srn_cls_e;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    // Maps a select value onto its operation class.
    function automatic srn_cls_e classify(input logic [3:0] op);
        if (op <= 4'd6)                    return CLS_FULL;
        if (op >= 4'd8 && op <= 4'd11)     return CLS_ACC;
        if (op == 4'd12 || op == 4'd13)    return CLS_NIB;
        return CLS_PASS;
    endfunction

endpackage

// File: rtl/srn_shift_core.sv
// One-position shifter/rotator. kind 0..6 selects circular left/right,
// through-carry left/right, arithmetic left, arithmetic right, logical
// right. Assumes W >= 2. Other kinds pass the data and carry unchanged.
module srn_shift_core #(
    parameter int W = 8
) (
    input  logic [2:0]   kind,
    input  logic [W-1:0] din,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout
);
    // Select the shifted value and the bit that leaves the word.
    always_comb begin
        dout = din;
        cout = cin;
        case (kind)
            3'd0: begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
            3'd1: begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
            3'd2: begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
            3'd3: begin dout = {cin, din[W-1:1]};      cout = din[0];   end
            3'd4: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
            3'd5: begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
            3'd6: begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
            default: ;
        endcase
    end
endmodule

// File: rtl/srn_nibble_rot.sv
// Three-way half-word rotation between accumulator and a memory word.
// dir=0 moves mem low->mem high, mem high->acc low, acc low->mem low;
// dir=1 is the reverse cycle. The accumulator high half is never touched.
// Assumes W is even.
module srn_nibble_rot #(
    parameter int W = 8
) (
    input  logic         dir,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] m_out
);
    localparam int HW = W / 2;

    logic [HW-1:0] a_hi, a_lo, m_hi, m_lo;

    // Split both words into halves.
    always_comb begin
        a_hi = a_in[W-1:HW];
        a_lo = a_in[HW-1:0];
        m_hi = m_in[W-1:HW];
        m_lo = m_in[HW-1:0];
    end

    // Route the three movable halves in the chosen direction.
    always_comb begin
        if (dir) begin
            a_out = {a_hi, m_lo};
            m_out = {a_lo, m_hi};
        end else begin
            a_out = {a_hi, m_hi};
            m_out = {m_lo, a_lo};
        end
    end
endmodule

// File: rtl/srn_flag_gen.sv
// Builds the outgoing flag byte from the operation class, the shifter
// result and carry, and the new accumulator of a nibble rotation.
// Bits without a defined role pass from flags_in.
module srn_flag_gen
    import srn_pkg::*;
#(
    parameter int W = 8
) (
    input  srn_cls_e     cls,
    input  logic [W-1:0] sh_res,
    input  logic         sh_c,
    input  logic [W-1:0] nib_a,
    input  logic [7:0]   flags_in,
    output logic [7:0]   flags_out
);
    logic [W-1:0] probe;

    // Value whose sign, zero and parity are reported.
    always_comb probe = (cls == CLS_NIB) ? nib_a : sh_res;

    // Per-class flag update.
    always_comb begin
        flags_out = flags_in;
        case (cls)
            CLS_FULL, CLS_NIB: begin
                flags_out[FL_S]  = probe[W-1];
                flags_out[FL_Z]  = (probe == '0);
                flags_out[FL_PV] = ~(^probe);
                flags_out[FL_H]  = 1'b0;
                flags_out[FL_N]  = 1'b0;
                if (cls == CLS_FULL) flags_out[FL_C] = sh_c;
            end
            CLS_ACC: begin
                flags_out[FL_H] = 1'b0;
                flags_out[FL_N] = 1'b0;
                flags_out[FL_C] = sh_c;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/srn_unit.sv
// Shift, rotate and nibble-rotate unit, top level. Decodes op_sel, feeds
// operand or accumulator to the shifter, runs the nibble rotator and flag
// builder, and registers all outputs (OUT_REG=1) or passes them through.
// Assumes the caller handles operand muxing and memory access.
module srn_unit
    import srn_pkg::*;
#(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mem_in,
    input  logic [7:0]   flags_in,
    output logic [W-1:0] result,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] mem_out,
    output logic [7:0]   flags_out
);
    srn_cls_e     cls;
    logic [2:0]   kind;
    logic [W-1:0] sh_in, sh_out, nib_a, nib_m;
    logic         sh_c;
    logic [W-1:0] res_c, acc_c, mem_c;
    logic [7:0]   flg_c;

    // Decode class and shifter kind from the select.
    always_comb begin
        cls   = classify(op_sel);
        kind  = (cls == CLS_ACC) ? {1'b0, op_sel[1:0]} : op_sel[2:0];
        sh_in = (cls == CLS_ACC) ? acc_in : operand;
    end

    srn_shift_core #(.W(W)) u_shift (
        .kind (kind),
        .din  (sh_in),
        .cin  (flags_in[FL_C]),
        .dout (sh_out),
        .cout (sh_c)
    );

    srn_nibble_rot #(.W(W)) u_nib (
        .dir   (op_sel[0]),
        .a_in  (acc_in),
        .m_in  (mem_in),
        .a_out (nib_a),
        .m_out (nib_m)
    );

    srn_flag_gen #(.W(W)) u_flag (
        .cls       (cls),
        .sh_res    (sh_out),
        .sh_c      (sh_c),
        .nib_a     (nib_a),
        .flags_in  (flags_in),
        .flags_out (flg_c)
    );

    // Choose which datapath drives each output word.
    always_comb begin
        res_c = operand;
        acc_c = acc_in;
        mem_c = mem_in;
        case (cls)
            CLS_FULL: res_c = sh_out;
            CLS_ACC:  begin res_c = sh_out; acc_c = sh_out; end
            CLS_NIB:  begin res_c = nib_a;  acc_c = nib_a; mem_c = nib_m; end
            default:  ;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            // Output register with synchronous active-low clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result    <= '0;
                    acc_out   <= '0;
                    mem_out   <= '0;
                    flags_out <= '0;
                end else begin
                    result    <= res_c;
                    acc_out   <= acc_c;
                    mem_out   <= mem_c;
                    flags_out <= flg_c;
                end
            end

            // R6
            acc_szp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(classify(op_sel)) == CLS_ACC) |->
                (flags_out[FL_S] == $past(flags_in[FL_S]) &&
                 flags_out[FL_Z] == $past(flags_in[FL_Z]) &&
                 flags_out[FL_PV] == $past(flags_in[FL_PV]) &&
                 acc_out == result));

            // R7
            nib_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(classify(op_sel)) == CLS_NIB) |->
                ($countones({acc_out, mem_out}) ==
                 $countones({$past(acc_in), $past(mem_in)}) &&
                 acc_out[W-1:W/2] == $past(acc_in[W-1:W/2])));

            // R9
            nib_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(classify(op_sel)) == CLS_NIB) |->
                (flags_out[FL_C] == $past(flags_in[FL_C]) &&
                 flags_out[FL_Z] == (acc_out == '0)));

            // R5
            full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(classify(op_sel)) == CLS_FULL) |->
                (flags_out[FL_Z] == (result == '0) &&
                 flags_out[FL_PV] == ($countones(result) % 2 == 0) &&
                 !flags_out[FL_H] && !flags_out[FL_N]));

            // R10
            spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |->
                (flags_out[5] == $past(flags_in[5]) &&
                 flags_out[3] == $past(flags_in[3])));

            // R11
            reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(classify(op_sel)) == CLS_PASS) |->
                (flags_out == $past(flags_in) && result == $past(operand)));
        end else begin : g_comb
            always_comb begin
                result    = res_c;
                acc_out   = acc_c;
                mem_out   = mem_c;
                flags_out = flg_c;
            end
        end
    endgenerate
endmodule

// File: tb/srn_unit_test.sv
// Self-checking bench for srn_unit: directed corner bytes, then seeded
// random stimulus over every select value, compared against a model.
module srn_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] operand = '0, acc_in = '0, mem_in = '0, flags_in = '0;
    logic [7:0] result, acc_out, mem_out, flags_out;

    int checks = 0;
    int errors = 0;

    srn_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
        .acc_in(acc_in), .mem_in(mem_in), .flags_in(flags_in),
        .result(result), .acc_out(acc_out), .mem_out(mem_out),
        .flags_out(flags_out)
    );

    always #2 clk = ~clk;

    // Expected {result, acc, mem, flags} from the requirements.
    function automatic logic [31:0] model(input logic [3:0] op,
            input logic [7:0] x, input logic [7:0] a,
            input logic [7:0] m, input logic [7:0] f);
        logic [7:0] r, na, nm, nf, src;
        logic c, co;
        c = f[0]; r = x; na = a; nm = m; nf = f; co = c;
        src = (op >= 4'd8) ? a : x;
        case (op)
            4'd0, 4'd8:  begin r = (src << 1) | (src >> 7); co = src[7]; end
            4'd1, 4'd9:  begin r = (src >> 1) | (src << 7); co = src[0]; end
            4'd2, 4'd10: begin r = (src << 1) | (c ? 8'h01 : 8'h00); co = src[7]; end
            4'd3, 4'd11: begin r = (src >> 1) | (c ? 8'h80 : 8'h00); co = src[0]; end
            4'd4: begin r = src << 1; co = src[7]; end
            4'd5: begin r = (src >> 1) | (src & 8'h80); co = src[0]; end
            4'd6: begin r = src >> 1; co = src[0]; end
            4'd12: begin na = {a[7:4], m[7:4]}; nm = {m[3:0], a[3:0]}; r = na; end
            4'd13: begin na = {a[7:4], m[3:0]}; nm = {a[3:0], m[7:4]}; r = na; end
            default: ;
        endcase
        if (op <= 4'd6 || op == 4'd12 || op == 4'd13) begin
            nf[7] = r[7];
            nf[6] = (r == 8'h00);
            nf[2] = ($countones(r) % 2 == 0);
            nf[4] = 1'b0; nf[1] = 1'b0;
            if (op <= 4'd6) nf[0] = co;
        end else if (op >= 4'd8 && op <= 4'd11) begin
            nf[4] = 1'b0; nf[1] = 1'b0; nf[0] = co;
            na = r;
        end
        return {r, na, nm, nf};
    endfunction

    function automatic string data_tag(input logic [3:0] op);
        if (op <= 4'd1) return "R2";
        if (op <= 4'd3) return "R3";
        if (op <= 4'd6) return "R4";
        if (op >= 4'd8 && op <= 4'd11) return "R6";
        if (op == 4'd12) return "R7";
        if (op == 4'd13) return "R8";
        return "R11";
    endfunction

    function automatic string flag_tag(input logic [3:0] op);
        if (op <= 4'd6) return "R5";
        if (op >= 4'd8 && op <= 4'd11) return "R6";
        if (op == 4'd12 || op == 4'd13) return "R9";
        return "R11";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic run_op(input logic [3:0] op, input logic [7:0] x,
                          input logic [7:0] a, input logic [7:0] m,
                          input logic [7:0] f);
        logic [31:0] e;
        string ptag;
        op_sel = op; operand = x; acc_in = a; mem_in = m; flags_in = f;
        e = model(op, x, a, m, f);
        @(negedge clk);
        ptag = (op <= 4'd6) ? "R12" : data_tag(op);
        check(data_tag(op), "result", result, e[31:24]);
        check(ptag, "acc_out", acc_out, e[23:16]);
        check(ptag, "mem_out", mem_out, e[15:8]);
        check(flag_tag(op), "flags_out", flags_out, e[7:0]);
        check("R10", "flag bits 5,3", flags_out & 8'h28, f & 8'h28);
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        op_sel = 4'd12; operand = 8'hA5; acc_in = 8'h5A; mem_in = 8'hC3; flags_in = 8'hFF;
        @(negedge clk);
        check("R1", "result in reset", result, 8'h00);
        check("R1", "acc_out in reset", acc_out, 8'h00);
        check("R1", "mem_out in reset", mem_out, 8'h00);
        check("R1", "flags_out in reset", flags_out, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        reset_check();
        // Directed edge-bit cases.
        run_op(4'd0, 8'h80, 8'h00, 8'h00, 8'h00); // R2 -> 01, C=1
        run_op(4'd1, 8'h01, 8'h00, 8'h00, 8'h00); // R2 -> 80, C=1
        run_op(4'd2, 8'h80, 8'h00, 8'h00, 8'h01); // R3 -> 01, C=1
        run_op(4'd3, 8'h00, 8'h00, 8'h00, 8'h01); // R3 -> 80, C=0
        run_op(4'd4, 8'h80, 8'h00, 8'h00, 8'hFF); // R4 -> 00, Z=1
        run_op(4'd5, 8'h81, 8'h00, 8'h00, 8'h00); // R4 -> C0
        run_op(4'd6, 8'h81, 8'h00, 8'h00, 8'h01); // R4 -> 40
        run_op(4'd8, 8'hFF, 8'h80, 8'h00, 8'hC4); // R6 keeps S,Z,PV
        run_op(4'd11, 8'h00, 8'h01, 8'h00, 8'h00); // R6
        run_op(4'd12, 8'h00, 8'h12, 8'h34, 8'h01); // R7 acc 13 mem 42
        run_op(4'd13, 8'h00, 8'h12, 8'h34, 8'h00); // R8 acc 14 mem 23
        run_op(4'd12, 8'h00, 8'h00, 8'h00, 8'h00); // R9 zero acc
        run_op(4'd7, 8'h3C, 8'h11, 8'h22, 8'hD7);  // R11
        run_op(4'd15, 8'hE1, 8'h33, 8'h44, 8'h28); // R11
        // Random mix over all selects.
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom));
        end
        reset_check();
        run_op(4'd9, 8'h00, 8'h01, 8'h00, 8'h00);  // R6 after reset, R1 latency
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule